// File: doc/BRIEF.md
# Serial-Programmed Multichannel Level Code Bank

This block holds twelve 10-bit level codes that a host writes over a three-wire serial link. The link has an active-low frame enable, a serial clock and a data line. While the enable is low, the block takes in a 16-bit frame, most significant bit first. When the enable returns high after exactly sixteen bits, the block loads the code into the channel that the frame names. All twelve codes are available in parallel at all times. Each channel also has a one-cycle strobe that marks each update.

The block runs on a fast system clock and oversamples the serial lines through two-flop synchronisers. It finds the serial clock and enable edges in the system clock domain. A serial data output repeats the bits that leave the top of the shift register. This output changes on falling serial clock edges, so several banks can be chained on one link.

Top module: `level_code_bank`

## Requirements
- R1: After reset every channel code reads 0x200, all update strobes are low and the serial data output is low.
- R2: A frame has 16 bits, sent most significant bit first. Frame bits 15:12 carry the channel address (0 to 11) and bits 9:0 carry the code. When the enable rises after exactly 16 sampled bits, the addressed channel takes the code and every other channel keeps its value.
- R3: Frame bits 11:10 are ignored. A frame whose reserved bits are set writes the same code as one whose reserved bits are clear.
- R4: A 16-bit frame with an address of 12 to 15 changes no channel and raises no strobe.
- R5: If the enable rises after any bit count other than 16, the frame is discarded. No channel changes and no strobe fires.
- R6: Serial clock edges while the enable is high shift nothing and change nothing.
- R7: A rising serial clock edge that the block sees in the same cycle as the falling enable edge is not counted as a data bit.
- R8: The serial data output is low while the enable is high. From the falling enable edge on, it carries shift register bit 15. It is refreshed on each falling serial clock edge, so a downstream bank receives the previous 16 shifted bits, most significant bit first.
- R9: Each accepted write raises the strobe of the written channel for exactly one system clock cycle. At most one strobe is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| serEnN | input | 1 | Active-low frame enable |
| serClk | input | 1 | Serial clock; data is sampled on its rising edge |
| serDin | input | 1 | Serial data in |
| serDout | output | 1 | Serial data out for chaining |
| codeFlat | output | 120 | All channel codes; channel n in bits n*10+9 : n*10 |
| updStb | output | 12 | One-cycle update strobe per channel |

## Verification
On every cycle, the embedded assertions check four things. At most one strobe is high, and a strobe never lasts two cycles. Codes change only in a cycle with a strobe. The shift register holds still and the serial output stays low while the enable is high. The bit counter never passes its saturation value. Other behaviours can only be shown by the bench's scenarios: which channel a frame lands in, frames that are discarded for a wrong length or an out-of-range address, the reserved bits having no effect, a clock edge that coincides with the enable falling, and the bit stream seen by a downstream bank. The bench compares these with a model of the shift register and a table of expected codes.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  // Strobes from the serial control to the datapath, one system cycle each
  typedef struct packed {
    logic shiftEn;   // take one data bit
    logic commit;    // frame complete with exact length
    logic sdoLoad;   // refresh the chained output
    logic idle;      // synchronised enable is high
  } lvlCtl_t;
endpackage

// File: rtl/lvl_ctrl.sv
module lvl_ctrl
  import lvl_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serEnN,
  output lvlCtl_t ctl
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0] clkSync;
  logic [1:0] enSync;
  logic       clkDly;
  logic       enDly;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= 2'b00;
      enSync  <= 2'b11;
      clkDly  <= 1'b0;
      enDly   <= 1'b1;
    end else begin
      clkSync <= {clkSync[0], serClk};
      enSync  <= {enSync[0], serEnN};
      clkDly  <= clkSync[1];
      enDly   <= enSync[1];
    end
  end

  logic clkS, enS, clkRise, clkFall, enFall, enRise;
  assign clkS    = clkSync[1];
  assign enS     = enSync[1];
  assign clkRise = clkS & ~clkDly;
  assign clkFall = ~clkS & clkDly;
  assign enFall  = ~enS & enDly;
  assign enRise  = enS & ~enDly;

  always_comb begin
    ctl.idle    = enS;
    ctl.shiftEn = clkRise & ~enS & ~enFall;        // R7: coincident edge dropped
    ctl.sdoLoad = (clkFall & ~enS) | enFall;
    ctl.commit  = enRise && (bitCnt == CNT_W'(FRAME_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (enFall || enRise) begin
      bitCnt <= '0;
    end else if (ctl.shiftEn && bitCnt != CNT_W'(CNT_MAX)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CNT_MAX)); // R5
  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (enS && enDly) |-> bitCnt == '0); // R6
endmodule

// File: rtl/lvl_datapath.sv
module lvl_datapath
  import lvl_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int CODE_W  = 10,
  parameter int ADDR_W  = 4,
  parameter int FRAME_W = 16,
  parameter logic [CODE_W-1:0] RST_CODE = CODE_W'(1 << (CODE_W - 1))
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serDin,
  input  lvlCtl_t                  ctl,
  output logic                     serDout,
  output logic [NUM_CH*CODE_W-1:0] codeFlat,
  output logic [NUM_CH-1:0]        updStb
);
  localparam int ADDR_LSB = FRAME_W - ADDR_W;

  logic [1:0]         dinSync;
  logic [FRAME_W-1:0] shiftReg;
  logic               sdoReg;
  logic [ADDR_W-1:0]  frameAddr;
  logic [CODE_W-1:0]  codeReg [NUM_CH];

  assign frameAddr = shiftReg[FRAME_W-1:ADDR_LSB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dinSync  <= 2'b00;
      shiftReg <= '0;
      sdoReg   <= 1'b0;
    end else begin
      dinSync <= {dinSync[0], serDin};
      if (ctl.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], dinSync[1]};
      if (ctl.idle)         sdoReg <= 1'b0;
      else if (ctl.sdoLoad) sdoReg <= shiftReg[FRAME_W-1];
    end
  end

  assign serDout = sdoReg;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeReg[ch] <= RST_CODE;
        updStb[ch]  <= 1'b0;
      end else if (ctl.commit && frameAddr == ADDR_W'(ch)) begin
        codeReg[ch] <= shiftReg[CODE_W-1:0];
        updStb[ch]  <= 1'b1;
      end else begin
        updStb[ch]  <= 1'b0;
      end
    end
    assign codeFlat[ch*CODE_W +: CODE_W] = codeReg[ch];
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(updStb)); // R9
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (updStb != '0) |=> (updStb == '0)); // R9
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (updStb == '0) |-> $stable(codeFlat)); // R2
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idle |=> $stable(shiftReg)); // R6
  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idle |=> !serDout); // R8
endmodule

// File: rtl/level_code_bank.sv
module level_code_bank
  import lvl_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int CODE_W  = 10,
  parameter int ADDR_W  = 4,
  parameter int FRAME_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serEnN,
  input  logic                     serClk,
  input  logic                     serDin,
  output logic                     serDout,
  output logic [NUM_CH*CODE_W-1:0] codeFlat,
  output logic [NUM_CH-1:0]        updStb
);
  lvlCtl_t ctl;

  lvl_ctrl #(.FRAME_W(FRAME_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serEnN (serEnN),
    .ctl    (ctl)
  );

  lvl_datapath #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W),
    .FRAME_W(FRAME_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .serDin   (serDin),
    .ctl      (ctl),
    .serDout  (serDout),
    .codeFlat (codeFlat),
    .updStb   (updStb)
  );
endmodule

// File: tb/level_code_bank_test.sv
`timescale 1ns/1ps
module level_code_bank_test;
  localparam int NCH = 12;
  localparam int CW  = 10;
  localparam int H   = 8;   // serial half period in system cycles

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEnN = 1'b1, serClk = 1'b0, serDin = 1'b0;
  logic serDout;
  logic [NCH*CW-1:0] codeFlat;
  logic [NCH-1:0] updStb;

  level_code_bank uut (
    .clk(clk), .rstN(rstN), .serEnN(serEnN), .serClk(serClk),
    .serDin(serDin), .serDout(serDout), .codeFlat(codeFlat), .updStb(updStb)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [CW-1:0] expCode [NCH];
  logic [15:0] modelSr = '0;
  int stbCnt [NCH];

  always @(negedge clk)
    for (int c = 0; c < NCH; c++) if (updStb[c]) stbCnt[c]++;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [CW-1:0] codeOf(input int c);
    return codeFlat[c*CW +: CW];
  endfunction

  task automatic checkCodes(input string req);
    int bad = -1;
    for (int c = 0; c < NCH; c++) if (bad < 0 && codeOf(c) !== expCode[c]) bad = c;
    if (bad < 0) check(1'b1, req, "codes", 0, 0);
    else check(1'b0, req, $sformatf("code ch%0d", bad), codeOf(bad), expCode[bad]);
  endtask

  task automatic idleToggles(input int n);
    bit lowOk = 1'b1;
    for (int i = 0; i < n; i++) begin
      serClk = 1'b1; waitCyc(H); if (serDout !== 1'b0) lowOk = 1'b0;
      serClk = 1'b0; waitCyc(H);
    end
    check(lowOk, "R6", "sdo during idle clocking", serDout, 0);
  endtask

  // Drive one frame of n bits (bits n-1 down to 0) and check the outcome.
  task automatic sendFrame(input logic [31:0] bits, input int n, input bit coincide,
                           input string req);
    bit sdoOk = 1'b1;
    int wantCh = -1;
    logic [3:0] addr;
    for (int c = 0; c < NCH; c++) stbCnt[c] = 0;
    if (coincide) begin
      serClk = 1'b1; serEnN = 1'b0; waitCyc(H);
      serClk = 1'b0; waitCyc(H);
    end else begin
      serEnN = 1'b0; waitCyc(H);
    end
    for (int i = n - 1; i >= 0; i--) begin
      serDin = bits[i]; waitCyc(H);
      if (serDout !== modelSr[15]) sdoOk = 1'b0;
      serClk = 1'b1; modelSr = {modelSr[14:0], bits[i]}; waitCyc(H);
      serClk = 1'b0;
    end
    waitCyc(H); serEnN = 1'b1; waitCyc(12);
    addr = bits[15:12];
    if (n == 16 && addr < NCH) begin
      wantCh = int'(addr);
      expCode[wantCh] = bits[9:0];
    end
    check(sdoOk, "R8", "chained output stream", 0, 0);
    check(serDout === 1'b0, "R8", "sdo low after frame", serDout, 0);
    checkCodes(req);
    for (int c = 0; c < NCH; c++) begin
      int want = (c == wantCh) ? 1 : 0;
      if (stbCnt[c] != want) begin
        check(1'b0, "R9", $sformatf("strobe count ch%0d", c), stbCnt[c], want);
        return;
      end
    end
    check(1'b1, "R9", "strobe counts", 0, 0);
  endtask

  function automatic logic [31:0] mkFrame(input int a, input int res, input int code);
    return {16'h0, 4'(a), 2'(res), 10'(code)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D));
    for (int c = 0; c < NCH; c++) expCode[c] = 10'h200;
    waitCyc(5); rstN = 1'b1; waitCyc(5);

    checkCodes("R1");
    check(updStb == '0, "R1", "strobes after reset", updStb, 0);
    check(serDout === 1'b0, "R1", "sdo after reset", serDout, 0);

    sendFrame(mkFrame(0, 0, 10'h155), 16, 1'b0, "R2");
    sendFrame(mkFrame(11, 0, 10'h3FF), 16, 1'b0, "R2");
    sendFrame(mkFrame(5, 3, 10'h0A7), 16, 1'b0, "R3");
    sendFrame(mkFrame(12, 0, 10'h111), 16, 1'b0, "R4");
    sendFrame(mkFrame(15, 1, 10'h222), 16, 1'b0, "R4");
    sendFrame(mkFrame(3, 0, 10'h0F0), 15, 1'b0, "R5");
    sendFrame({15'h0, 1'b1, mkFrame(4, 0, 10'h333)} , 17, 1'b0, "R5");
    sendFrame(mkFrame(7, 0, 10'h2C3), 16, 1'b1, "R7");
    idleToggles(3);
    sendFrame(mkFrame(2, 2, 10'h01E), 16, 1'b0, "R6");

    for (int k = 0; k < 40; k++) begin
      int a = $urandom % 16;
      int r = $urandom % 4;
      int cd = $urandom % 1024;
      int sel = $urandom % 6;
      int n = (sel == 0) ? 15 : (sel == 1) ? 17 : 16;
      logic [31:0] f = mkFrame(a, r, cd) | ({31'h0, 1'($urandom)} << 16);
      if ($urandom % 4 == 0) idleToggles(1 + $urandom % 3);
      sendFrame(f, n, ($urandom % 4) == 0, "R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule